// File: doc/BRIEF.md
# Bufferless Deflection Switch

This block is a single router node for a two-dimensional network-on-chip in which no flit is ever held back. Four network links (north, east, south, west) bring in at most one flit each per clock, and every flit that arrives leaves on some link exactly one clock later. A flit is not tied to a packet at the switch. Each flit is placed on a link that brings it closer to its destination when one is free. If none is free, it is sent out on a spare link. No link carries backpressure, and the switch stores nothing beyond its output registers.

The local processing element gets two services. A flit addressed to this node's coordinates is handed to the ejection port, at most one per clock. The element may also present a flit for injection. The switch takes it only when fewer than four network flits arrived in that cycle, and otherwise the element holds its request. Each flit carries its destination, an age that grows by one per hop, and its index within its packet, so that the receiver can place flits that arrive out of order. A parameter selects mesh routing or torus routing. In torus routing each dimension takes the shorter way around the ring.

Top module: `defl_switch`

## Requirements
- R1: A flit is packed from most to least significant bit as {valid, dest_x[XW], dest_y[YW], age[AW], seq[SW], data[DW]}. Every flit output is registered. A flit presented in one cycle appears on its output after the next rising edge, and reset clears every output to all zeros.
- R2: Ports are indexed north=0, east=1, south=2, west=3, with Y growing toward north. In mesh mode east is productive when dest_x > my_x, west when dest_x < my_x, north when dest_y > my_y and south when dest_y < my_y. A flit takes the lowest-index productive port that is still free.
- R3: In torus mode (TORUS=1) let d be the forward distance (dest - my) mod DIM in a dimension. If d is zero, that dimension is not productive. If 2*d <= DIM, east (or north) is productive; otherwise west (or south) is.
- R4: Network flits are allocated one after another in order of decreasing age. Equal ages go lowest port index first.
- R5: A flit with no free productive port is deflected to the lowest-index free port. Every network flit that is not ejected leaves on exactly one network output.
- R6: A flit whose destination equals (my_x, my_y) is eligible for ejection. Only the oldest eligible flit is ejected, with equal ages going to the lowest port index. Any other local flit is deflected like a normal flit.
- R7: inj_ack is high, combinationally in the same cycle, exactly when inj_req is high and fewer than four network inputs carry valid flits. An accepted flit is allocated after all network flits, using the same productive-then-free rule, and leaves with its valid bit set.
- R8: Every flit leaving on a network port has its age increased by one, saturating at the all-ones value. The ejected flit leaves with its fields unchanged.
- R9: A refused injection has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_x | input | XW | X coordinate of this node |
| my_y | input | YW | Y coordinate of this node |
| net_in | input | 4*FW | Incoming flits, port p at bits [p*FW +: FW] |
| inj_req | input | 1 | Local element offers a flit |
| inj_flit | input | FW | Flit offered for injection (its valid bit is ignored) |
| inj_ack | output | 1 | Offered flit accepted this cycle |
| net_out | output | 4*FW | Outgoing flits, port p at bits [p*FW +: FW] |
| ej_out | output | FW | Flit delivered to the local element |

## Verification
The hardest situation to reach is full contention. In that case several flits want the same link, one of them is local while another local flit competes for ejection, and their ages tie, so the priority, ejection and deflection rules all decide the same cycle. Directed vectors build these collisions by hand, including the torus tie at half the ring and four-flit arrivals that refuse an injection. A long run of dense random traffic then follows, with many local destinations and saturated ages. A behavioural model in the bench checks every output of a mesh instance and a torus instance on every clock.

// File: rtl/defl_pkg.sv
package defl_pkg;
   localparam int NPORT = 4;
   localparam int PN    = 0;
   localparam int PE    = 1;
   localparam int PS    = 2;
   localparam int PW    = 3;
   localparam logic [2:0] SRC_INJ = 3'd4;
endpackage

// File: rtl/defl_route.sv
module defl_route #(
   parameter int DIM_X = 4,
   parameter int DIM_Y = 4,
   parameter bit TORUS = 1'b0,
   localparam int XW = $clog2(DIM_X),
   localparam int YW = $clog2(DIM_Y)
) (
   input  logic [XW-1:0] cur_x,
   input  logic [YW-1:0] cur_y,
   input  logic [XW-1:0] dst_x,
   input  logic [YW-1:0] dst_y,
   output logic [3:0]    prod,
   output logic          here
);
   import defl_pkg::*;

   assign here = (dst_x == cur_x) && (dst_y == cur_y);

   generate
      if (TORUS) begin : g_torus
         int fx, fy;
         always_comb begin
            fx = (dst_x >= cur_x) ? int'(dst_x) - int'(cur_x)
                                  : int'(dst_x) + DIM_X - int'(cur_x);
            fy = (dst_y >= cur_y) ? int'(dst_y) - int'(cur_y)
                                  : int'(dst_y) + DIM_Y - int'(cur_y);
            prod     = '0;
            prod[PE] = (fx != 0) && (2 * fx <= DIM_X);
            prod[PW] = (fx != 0) && (2 * fx >  DIM_X);
            prod[PN] = (fy != 0) && (2 * fy <= DIM_Y);
            prod[PS] = (fy != 0) && (2 * fy >  DIM_Y);
         end
      end else begin : g_mesh
         always_comb begin
            prod     = '0;
            prod[PE] = dst_x > cur_x;
            prod[PW] = dst_x < cur_x;
            prod[PN] = dst_y > cur_y;
            prod[PS] = dst_y < cur_y;
         end
      end
   endgenerate
endmodule

// File: rtl/defl_eject.sv
module defl_eject #(
   parameter int AW = 3
) (
   input  logic [3:0]         cand,
   input  logic [3:0][AW-1:0] age,
   output logic [3:0]         ej_oh
);
   logic          found;
   logic [1:0]    bi;
   logic [AW-1:0] bage;

   always_comb begin
      found = 1'b0;
      bi    = '0;
      bage  = '0;
      for (int i = 0; i < 4; i++) begin
         if (cand[i] && (!found || age[i] > bage)) begin
            found = 1'b1;
            bi    = 2'(i);
            bage  = age[i];
         end
      end
      ej_oh = '0;
      if (found) ej_oh[bi] = 1'b1;
   end
endmodule

// File: rtl/defl_alloc.sv
module defl_alloc #(
   parameter int AW = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [3:0]         act,
   input  logic [3:0][3:0]    prod,
   input  logic [3:0][AW-1:0] age,
   input  logic               inj_ok,
   input  logic [3:0]         inj_prod,
   output logic [3:0]         used,
   output logic [3:0][2:0]    src
);
   import defl_pkg::*;

   logic [3:0][2:0] rank;
   logic            got;

   always_comb begin
      for (int i = 0; i < 4; i++) begin
         rank[i] = '0;
         for (int j = 0; j < 4; j++) begin
            if (act[j] && j != i &&
                (age[j] > age[i] || (age[j] == age[i] && j < i)))
               rank[i] = rank[i] + 3'd1;
         end
      end
   end

   always_comb begin
      used = '0;
      src  = '0;
      got  = 1'b0;
      for (int r = 0; r < 4; r++) begin
         for (int i = 0; i < 4; i++) begin
            if (act[i] && rank[i] == 3'(r)) begin
               got = 1'b0;
               for (int o = 0; o < 4; o++)
                  if (!got && prod[i][o] && !used[o]) begin
                     used[o] = 1'b1; src[o] = 3'(i); got = 1'b1;
                  end
               for (int o = 0; o < 4; o++)
                  if (!got && !used[o]) begin
                     used[o] = 1'b1; src[o] = 3'(i); got = 1'b1;
                  end
            end
         end
      end
      if (inj_ok) begin
         got = 1'b0;
         for (int o = 0; o < 4; o++)
            if (!got && inj_prod[o] && !used[o]) begin
               used[o] = 1'b1; src[o] = SRC_INJ; got = 1'b1;
            end
         for (int o = 0; o < 4; o++)
            if (!got && !used[o]) begin
               used[o] = 1'b1; src[o] = SRC_INJ; got = 1'b1;
            end
      end
   end

   generate
      for (genvar o = 0; o < 4; o++) begin : g_chk
         AST_LEADER_PRODUCTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (used[o] && src[o] != SRC_INJ && rank[src[o][1:0]] == 3'd0 &&
             |prod[src[o][1:0]]) |-> prod[src[o][1:0]][o]); // R4
      end
   endgenerate

   AST_ALL_PLACED: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(used) == $countones(act) + 32'(inj_ok)); // R5
endmodule

// File: rtl/defl_switch.sv
module defl_switch #(
   parameter int DIM_X = 4,
   parameter int DIM_Y = 4,
   parameter bit TORUS = 1'b0,
   parameter int AW    = 3,
   parameter int SW    = 4,
   parameter int DW    = 8,
   localparam int XW   = $clog2(DIM_X),
   localparam int YW   = $clog2(DIM_Y),
   localparam int FW   = 1 + XW + YW + AW + SW + DW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [XW-1:0]   my_x,
   input  logic [YW-1:0]   my_y,
   input  logic [4*FW-1:0] net_in,
   input  logic            inj_req,
   input  logic [FW-1:0]   inj_flit,
   output logic            inj_ack,
   output logic [4*FW-1:0] net_out,
   output logic [FW-1:0]   ej_out
);
   import defl_pkg::*;

   localparam int AGE_LO = DW + SW;
   localparam int Y_LO   = AGE_LO + AW;
   localparam int X_LO   = Y_LO + YW;
   localparam int V_BIT  = X_LO + XW;

   if (DIM_X < 2 || DIM_Y < 2 || AW < 1 || SW < 1 || DW < 1) begin : g_bad_cfg
      $error("defl_switch: dimensions must be >= 2 and field widths >= 1");
   end

   logic [FW-1:0]      fl [5];
   logic [3:0]         vin, here_v, ej_oh, act, used;
   logic [4:0][3:0]    prod_all;
   logic [4:0]         here_all;
   logic [3:0][3:0]    prod_net;
   logic [3:0][AW-1:0] age_net;
   logic [3:0][2:0]    src;
   logic               inj_ok;
   logic [FW-1:0]      out_d [4];
   logic [FW-1:0]      out_q [4];
   logic [FW-1:0]      ej_d, ej_q;
   logic               started;

   generate
      for (genvar p = 0; p < 5; p++) begin : g_route
         if (p < 4) begin : g_net
            assign fl[p] = net_in[p*FW +: FW];
         end else begin : g_inj
            assign fl[p] = inj_flit;
         end
         defl_route #(.DIM_X(DIM_X), .DIM_Y(DIM_Y), .TORUS(TORUS)) u_route (
            .cur_x(my_x), .cur_y(my_y),
            .dst_x(fl[p][X_LO +: XW]), .dst_y(fl[p][Y_LO +: YW]),
            .prod(prod_all[p]), .here(here_all[p]));
      end
      for (genvar p = 0; p < 4; p++) begin : g_unpack
         assign vin[p]      = fl[p][V_BIT];
         assign here_v[p]   = here_all[p];
         assign prod_net[p] = prod_all[p];
         assign age_net[p]  = fl[p][AGE_LO +: AW];
         assign net_out[p*FW +: FW] = out_q[p];
      end
   endgenerate

   defl_eject #(.AW(AW)) u_eject (
      .cand(vin & here_v), .age(age_net), .ej_oh(ej_oh));

   assign act     = vin & ~ej_oh;
   assign inj_ok  = inj_req && ($countones(vin) < 4);
   assign inj_ack = inj_ok;

   defl_alloc #(.AW(AW)) u_alloc (
      .clk(clk), .rst_n(rst_n), .act(act), .prod(prod_net), .age(age_net),
      .inj_ok(inj_ok), .inj_prod(prod_all[4]), .used(used), .src(src));

   always_comb begin
      for (int o = 0; o < 4; o++) begin
         out_d[o] = '0;
         if (used[o]) begin
            out_d[o] = (src[o] == SRC_INJ) ? fl[4] : fl[src[o][1:0]];
            out_d[o][V_BIT] = 1'b1;
            if (out_d[o][AGE_LO +: AW] != {AW{1'b1}})
               out_d[o][AGE_LO +: AW] = out_d[o][AGE_LO +: AW] + 1'b1;
         end
      end
      ej_d = '0;
      for (int i = 0; i < 4; i++)
         if (ej_oh[i]) ej_d = fl[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int o = 0; o < 4; o++) out_q[o] <= '0;
         ej_q    <= '0;
         started <= 1'b0;
      end else begin
         for (int o = 0; o < 4; o++) out_q[o] <= out_d[o];
         ej_q    <= ej_d;
         started <= 1'b1;
      end
   end

   assign ej_out = ej_q;

   AST_FLIT_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> ($countones({out_q[0][V_BIT], out_q[1][V_BIT], out_q[2][V_BIT],
                               out_q[3][V_BIT], ej_q[V_BIT]})
                   == $past($countones(vin)) + 32'($past(inj_ack)))); // R5
   AST_EJECT_IS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      (started && ej_q[V_BIT]) |->
         (ej_q[X_LO +: XW] == $past(my_x) && ej_q[Y_LO +: YW] == $past(my_y))); // R6
   AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
      (&vin) |-> !inj_ack); // R7
   AST_AGE_ADVANCED: assert property (@(posedge clk) disable iff (!rst_n)
      (started && out_q[0][V_BIT]) |-> (out_q[0][AGE_LO +: AW] != '0)); // R8
endmodule

// File: tb/tb_defl_switch.sv
module tb_defl_switch;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int XW = 2, YW = 2, AW = 3, SW = 4, DW = 8, DIM = 4;
   localparam int FW = 1 + XW + YW + AW + SW + DW;
   localparam int AGE_LO = DW + SW, Y_LO = AGE_LO + AW, X_LO = Y_LO + YW;
   localparam int V_BIT = X_LO + XW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [4*FW-1:0] net_in = '0;
   logic inj_req = 1'b0;
   logic [FW-1:0] inj_flit = '0;
   logic ack_m, ack_t;
   logic [4*FW-1:0] out_m, out_t;
   logic [FW-1:0] ej_m, ej_t;
   int checks = 0, fails = 0;
   logic [FW-1:0] exp_om [4], exp_ot [4];
   logic [FW-1:0] exp_em, exp_et;
   bit exp_am, exp_at;

   always #2.5 clk = ~clk;

   defl_switch dut (.clk(clk), .rst_n(rst_n), .my_x(2'd1), .my_y(2'd2),
      .net_in(net_in), .inj_req(inj_req), .inj_flit(inj_flit),
      .inj_ack(ack_m), .net_out(out_m), .ej_out(ej_m));
   defl_switch #(.TORUS(1'b1)) dut_torus (.clk(clk), .rst_n(rst_n),
      .my_x(2'd0), .my_y(2'd0), .net_in(net_in), .inj_req(inj_req),
      .inj_flit(inj_flit), .inj_ack(ack_t), .net_out(out_t), .ej_out(ej_t));

   function automatic logic [FW-1:0] mk(bit v, int x, int y, int age, int seq, int data);
      logic [FW-1:0] f = '0;
      f[V_BIT] = v; f[X_LO +: XW] = XW'(x); f[Y_LO +: YW] = YW'(y);
      f[AGE_LO +: AW] = AW'(age); f[DW +: SW] = SW'(seq); f[0 +: DW] = DW'(data);
      return f;
   endfunction

   task automatic chk(bit ok, string tag, logic [FW-1:0] act, logic [FW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // productive-direction mask: bit0 north, bit1 east, bit2 south, bit3 west
   function automatic logic [3:0] pmask(int dx, int dy, int mx, int my, bit tor);
      logic [3:0] m = '0;
      int d;
      if (tor) begin
         d = (dx - mx + DIM) % DIM;
         if (d != 0) begin if (2 * d <= DIM) m[1] = 1; else m[3] = 1; end
         d = (dy - my + DIM) % DIM;
         if (d != 0) begin if (2 * d <= DIM) m[0] = 1; else m[2] = 1; end
      end else begin
         if (dx > mx) m[1] = 1;
         if (dx < mx) m[3] = 1;
         if (dy > my) m[0] = 1;
         if (dy < my) m[2] = 1;
      end
      return m;
   endfunction

   function automatic logic [FW-1:0] hop(logic [FW-1:0] f);
      logic [FW-1:0] g = f;
      g[V_BIT] = 1'b1;
      if (int'(g[AGE_LO +: AW]) < (1 << AW) - 1) g[AGE_LO +: AW] = g[AGE_LO +: AW] + 1'b1;
      return g;
   endfunction

   task automatic model(input logic [FW-1:0] fin [4], input int mx, input int my,
                        input bit tor, output logic [FW-1:0] fo [4],
                        output logic [FW-1:0] fe, output bit ack);
      bit taken [4], busy [4];
      int ej = -1, nv = 0;
      for (int i = 0; i < 4; i++) begin
         fo[i] = '0; taken[i] = 0; busy[i] = 0;
         if (fin[i][V_BIT]) nv++;
      end
      fe = '0;
      for (int i = 0; i < 4; i++)
         if (fin[i][V_BIT] && int'(fin[i][X_LO +: XW]) == mx && int'(fin[i][Y_LO +: YW]) == my)
            if (ej < 0 || fin[i][AGE_LO +: AW] > fin[ej][AGE_LO +: AW]) ej = i;
      if (ej >= 0) begin fe = fin[ej]; taken[ej] = 1; end
      for (int k = 0; k < 5; k++) begin
         int best = -1;
         logic [FW-1:0] f;
         logic [3:0] pm;
         bit placed = 0;
         if (k < 4) begin
            for (int i = 0; i < 4; i++)
               if (fin[i][V_BIT] && !taken[i])
                  if (best < 0 || fin[i][AGE_LO +: AW] > fin[best][AGE_LO +: AW]) best = i;
            if (best < 0) continue;
            taken[best] = 1; f = fin[best];
         end else begin
            if (!(inj_req && nv < 4)) continue;
            f = inj_flit;
         end
         pm = pmask(f[X_LO +: XW], f[Y_LO +: YW], mx, my, tor);
         for (int o = 0; o < 4; o++)
            if (!placed && pm[o] && !busy[o]) begin busy[o] = 1; fo[o] = hop(f); placed = 1; end
         for (int o = 0; o < 4; o++)
            if (!placed && !busy[o]) begin busy[o] = 1; fo[o] = hop(f); placed = 1; end
      end
      ack = inj_req && nv < 4;
   endtask

   // drive one cycle of stimulus, check the combinational ack, then the registered outputs
   task automatic apply(input logic [FW-1:0] fin [4], input logic [FW-1:0] inj, input bit req);
      for (int p = 0; p < 4; p++) net_in[p*FW +: FW] = fin[p];
      inj_flit = inj; inj_req = req;
      #1;
      model(fin, 1, 2, 1'b0, exp_om, exp_em, exp_am);
      model(fin, 0, 0, 1'b1, exp_ot, exp_et, exp_at);
      chk(ack_m == exp_am, "R7 mesh inj_ack", FW'(ack_m), FW'(exp_am));
      chk(ack_t == exp_at, "R7 torus inj_ack", FW'(ack_t), FW'(exp_at));
      @(negedge clk);
      for (int p = 0; p < 4; p++) begin
         chk(out_m[p*FW +: FW] === exp_om[p], "R5 mesh net_out", out_m[p*FW +: FW], exp_om[p]);
         chk(out_t[p*FW +: FW] === exp_ot[p], "R3 torus net_out", out_t[p*FW +: FW], exp_ot[p]);
      end
      chk(ej_m === exp_em, "R6 mesh ej_out", ej_m, exp_em);
      chk(ej_t === exp_et, "R6 torus ej_out", ej_t, exp_et);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [FW-1:0] v [4];
      logic [FW-1:0] z = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(out_m === '0 && ej_m === '0, "R1 reset outputs", ej_m, z);
      chk(out_t === '0 && ej_t === '0, "R1 reset outputs torus", ej_t, z);
      rst_n = 1'b1;

      // R2 / R1: lone flit, mesh goes east one cycle later with age+1
      v = '{mk(1, 3, 2, 0, 1, 8'h11), z, z, z};
      apply(v, z, 0);
      chk(out_m[1*FW +: FW] === mk(1, 3, 2, 1, 1, 8'h11), "R2 mesh east",
          out_m[1*FW +: FW], mk(1, 3, 2, 1, 1, 8'h11));
      // R3: torus from x=0 to x=3 goes west
      v = '{mk(1, 3, 0, 2, 2, 8'h22), z, z, z};
      apply(v, z, 0);
      chk(out_t[3*FW +: FW] === mk(1, 3, 0, 3, 2, 8'h22), "R3 torus wrap west",
          out_t[3*FW +: FW], mk(1, 3, 0, 3, 2, 8'h22));
      // R4: older flit on south wins east, younger north flit deflected
      v = '{mk(1, 3, 2, 2, 3, 8'h33), z, mk(1, 3, 2, 5, 4, 8'h44), z};
      apply(v, z, 0);
      chk(out_m[1*FW +: FW] === mk(1, 3, 2, 6, 4, 8'h44), "R4 oldest wins",
          out_m[1*FW +: FW], mk(1, 3, 2, 6, 4, 8'h44));
      chk(out_m[0*FW +: FW] === mk(1, 3, 2, 3, 3, 8'h33), "R5 deflect lowest free",
          out_m[0*FW +: FW], mk(1, 3, 2, 3, 3, 8'h33));
      // R4: equal ages, lower port wins
      v = '{mk(1, 3, 2, 4, 5, 8'h55), z, mk(1, 3, 2, 4, 6, 8'h66), z};
      apply(v, z, 0);
      chk(out_m[1*FW +: FW] === mk(1, 3, 2, 5, 5, 8'h55), "R4 tie by port",
          out_m[1*FW +: FW], mk(1, 3, 2, 5, 5, 8'h55));
      // R6: two local flits, older one on west is ejected
      v = '{z, mk(1, 1, 2, 1, 7, 8'h77), z, mk(1, 1, 2, 4, 8, 8'h88)};
      apply(v, z, 0);
      chk(ej_m === mk(1, 1, 2, 4, 8, 8'h88), "R6 oldest ejected", ej_m, mk(1, 1, 2, 4, 8, 8'h88));
      // R7: three arrivals, injection accepted
      v = '{mk(1, 0, 0, 1, 1, 1), mk(1, 0, 0, 1, 2, 2), mk(1, 0, 0, 1, 3, 3), z};
      apply(v, mk(0, 3, 3, 0, 9, 8'h99), 1);
      // R9: four arrivals, injection refused and not visible
      v = '{mk(1, 0, 0, 1, 1, 1), mk(1, 0, 0, 1, 2, 2), mk(1, 0, 0, 1, 3, 3), mk(1, 3, 3, 0, 4, 4)};
      apply(v, mk(0, 2, 2, 0, 9, 8'hAA), 1);
      chk(ack_m == 1'b0, "R9 refused ack low", FW'(ack_m), z);
      // R8: saturated age stays at maximum
      v = '{z, z, z, mk(1, 3, 2, 7, 2, 8'hBB)};
      apply(v, z, 0);
      chk(out_m[1*FW +: FW] === mk(1, 3, 2, 7, 2, 8'hBB), "R8 age saturates",
          out_m[1*FW +: FW], mk(1, 3, 2, 7, 2, 8'hBB));

      // dense random traffic, heavy on local destinations and old ages
      for (int n = 0; n < 4000; n++) begin
         for (int p = 0; p < 4; p++) begin
            int x = $urandom_range(0, 3), y = $urandom_range(0, 3);
            if ($urandom_range(0, 3) == 0) begin x = 1; y = 2; end
            if ($urandom_range(0, 5) == 0) begin x = 0; y = 0; end
            v[p] = mk($urandom_range(0, 9) < 7, x, y, $urandom_range(0, 7),
                      $urandom_range(0, 15), $urandom_range(0, 255));
         end
         apply(v, mk($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3),
                     $urandom_range(0, 7), $urandom_range(0, 15), $urandom_range(0, 255)),
               $urandom_range(0, 1));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule